// File: doc/BRIEF.md
# EEPROM Identification Loader

After reset this block fetches a short configuration list from a serial EEPROM of 16-bit words and uses it to override six 16-bit identification registers (vendor, device, two class-code halves and the two subsystem fields). The list is sparse: it holds only the registers that should differ from their built-in values, as pairs of words. The first word of each pair carries a target number, a last-pair marker, reserved bits and a parity bit. The second word is the value to load. Pairs may come in any order.

The block runs the EEPROM's read command one word at a time over a four-wire serial link. It checks each pair for odd parity and for a legal target, and drops any pair that fails. It stops on the pair marked last, or at the end of the EEPROM's address space. The six registers are presented on one wide output bus. That bus shows the built-in values until loading has finished, then the loaded result. Two sticky flags report parity failures and malformed pairs.

Top module: `eeprom_id_loader`

## Requirements
- R1: Each word is fetched with one read frame. Chip select (`eeCs`) is high for the whole frame. On the first nine rising edges of `eeSk`, `eeDin` carries a start bit 1, opcode bits 1 then 0, and then the 6-bit word address MSB first. `eeSk` is low whenever `eeCs` is low, and each half period of `eeSk` lasts `SK_HALF` clocks.
- R2: The first frame after reset reads word 0. Each later frame reads the next word address, one higher than the last.
- R3: In the first word of a pair, bit 15 makes the 32-bit pair odd parity, bit 14 marks the last pair, bits 13:8 must be zero and bits 7:0 select the target. Target values 0 to 5 are legal. A well-formed pair loads its second word into the selected register.
- R4: The six registers reset to 0x13A8, 0x0352, 0x0200, 0x0700, 0x0000 and 0x0000 for targets 0 to 5. A register that no good pair names keeps that value after loading.
- R5: When more than one good pair names the same target, the one read last wins, whatever order the pairs come in.
- R6: A pair with even parity loads nothing and sets `parityErr`. The flag then stays high until reset, even when good pairs follow.
- R7: A pair whose bits 13:8 are nonzero, or whose target is above 5, loads nothing and sets `formatErr`. That flag is sticky until reset.
- R8: Loading ends after the pair whose bit 14 is 1, even when that pair is rejected. After that, `done` rises and no further frame is started.
- R9: If no pair carries the last-pair marker, loading ends after word 63. Exactly 64 words are read, and then `done` rises.
- R10: While `done` is low, `idWords` shows the reset values. Once `done` is high it stays high and `idWords` no longer changes.
- R11: Register k appears on `idWords[16k+15:16k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; loading starts when it is released |
| eeDout | input | 1 | Serial data from the EEPROM |
| eeCs | output | 1 | EEPROM chip select, active high |
| eeSk | output | 1 | EEPROM serial clock |
| eeDin | output | 1 | Serial command and address bits to the EEPROM |
| done | output | 1 | Loading has finished |
| parityErr | output | 1 | Sticky: a pair failed the odd parity check |
| formatErr | output | 1 | Sticky: a pair had nonzero reserved bits or an illegal target |
| idWords | output | 96 | The six identification registers, register k in bits 16k+15:16k |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- A rejected pair marked last. A design that honoured only good final markers would run on into the blank words.
- A good pair placed after the last-pair marker. A design that stopped late would apply it.
- A parity-bad pair followed by good ones. A design that cleared the flag would lose the error, and one that skipped the parity check would write the corrupt value.
- A list with no last-pair marker, followed by erased words. Here the first erased pair must be rejected for parity and still end the load.
- A fully populated EEPROM. A design without the word cap, or with an off-by-one in it, would read more or fewer than 64 words.
- A register read in the middle of a load. A design that exposed partial results early would already show a loaded value there.
- The address sequence and command bits seen by the EEPROM model, to catch a wrong opcode or a skipped address.

// File: rtl/idload_pkg.sv
`timescale 1ns/1ps
package idload_pkg;

  localparam int WORD_W  = 16;
  localparam int NUM_IDS = 6;
  localparam int TGT_W   = 8;

  // Address-word field positions
  localparam int PAR_BIT = 15;
  localparam int FIN_BIT = 14;
  localparam int RES_HI  = 13;
  localparam int RES_LO  = 8;

  typedef enum logic [1:0] {
    ST_GAP,
    ST_SHIFT,
    ST_COMMIT,
    ST_DONE
  } ldState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;     // capture one serial data bit
    logic commitWord;  // a full word sits in the shift register
    logic pairSecond;  // the committed word is the data half of a pair
  } dpStrobe_t;

  function automatic logic [WORD_W-1:0] idDefault(input int unsigned k);
    case (k)
      0:       idDefault = 16'h13A8;
      1:       idDefault = 16'h0352;
      2:       idDefault = 16'h0200;
      3:       idDefault = 16'h0700;
      default: idDefault = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/idload_ctrl.sv
`timescale 1ns/1ps
module idload_ctrl
  import idload_pkg::*;
#(
  parameter int SK_HALF = 2,
  parameter int ADDR_W  = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      finalFlag,
  output dpStrobe_t strb,
  output logic      eeCs,
  output logic      eeSk,
  output logic      eeDin,
  output logic      done
);

  localparam int DIV_W    = (SK_HALF > 1) ? $clog2(SK_HALF) : 1;
  localparam int CMD_LEN  = 3 + ADDR_W;
  localparam int BIT_LAST = CMD_LEN + WORD_W - 1;
  localparam int BIT_W    = $clog2(BIT_LAST + 1);
  localparam logic [ADDR_W-1:0] LAST_WORD = '1;

  ldState_t           state;
  logic [DIV_W-1:0]   divCnt;
  logic [BIT_W-1:0]   bitIdx;
  logic [ADDR_W-1:0]  wordAddr;
  logic               secondWord;
  logic               skLevel;
  logic               doneQ;
  logic               tick;
  logic [CMD_LEN-1:0] cmdWord;
  logic [CMD_LEN-1:0] cmdShifted;

  assign tick = (divCnt == DIV_W'(SK_HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_GAP;
      divCnt     <= '0;
      bitIdx     <= '0;
      wordAddr   <= '0;
      secondWord <= 1'b0;
      skLevel    <= 1'b0;
      doneQ      <= 1'b0;
    end else begin
      case (state)
        ST_GAP: begin
          if (tick) begin
            divCnt  <= '0;
            bitIdx  <= '0;
            skLevel <= 1'b0;
            state   <= ST_SHIFT;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            divCnt <= '0;
            if (!skLevel) begin
              skLevel <= 1'b1;
            end else begin
              skLevel <= 1'b0;
              if (bitIdx == BIT_W'(BIT_LAST)) state <= ST_COMMIT;
              else bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_COMMIT: begin
          if ((secondWord && finalFlag) || (wordAddr == LAST_WORD)) begin
            state <= ST_DONE;
            doneQ <= 1'b1;
          end else begin
            wordAddr   <= wordAddr + 1'b1;
            secondWord <= ~secondWord;
            divCnt     <= '0;
            state      <= ST_GAP;
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  // Command bits: start 1, opcode 10, then word address MSB first
  assign cmdWord    = {3'b110, wordAddr};
  assign cmdShifted = cmdWord << bitIdx;

  always_comb begin
    strb            = '0;
    strb.shiftIn    = (state == ST_SHIFT) && tick && skLevel &&
                      (bitIdx >= BIT_W'(CMD_LEN));
    strb.commitWord = (state == ST_COMMIT);
    strb.pairSecond = secondWord;
  end

  assign eeCs  = (state == ST_SHIFT);
  assign eeSk  = skLevel;
  assign eeDin = (state == ST_SHIFT) && (bitIdx < BIT_W'(CMD_LEN)) &&
                 cmdShifted[CMD_LEN-1];
  assign done  = doneQ;

endmodule

// File: rtl/idload_dp.sv
`timescale 1ns/1ps
module idload_dp
  import idload_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strb,
  input  logic                      eeDout,
  input  logic                      done,
  output logic                      finalFlag,
  output logic [NUM_IDS*WORD_W-1:0] idWords,
  output logic                      parityErr,
  output logic                      formatErr
);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] addrWord;
  logic [WORD_W-1:0] staged [NUM_IDS];
  logic              pairEnd;
  logic              pairOdd;
  logic              resvBad;
  logic              tgtBad;
  logic              pairGood;
  logic              perrQ;
  logic              ferrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.shiftIn) begin
      shiftReg <= {shiftReg[WORD_W-2:0], eeDout};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrWord <= '0;
    end else if (strb.commitWord && !strb.pairSecond) begin
      addrWord <= shiftReg;
    end
  end

  assign pairEnd  = strb.commitWord && strb.pairSecond;
  assign pairOdd  = ^{addrWord, shiftReg};
  assign resvBad  = |addrWord[RES_HI:RES_LO];
  assign tgtBad   = addrWord[TGT_W-1:0] >= TGT_W'(NUM_IDS);
  assign pairGood = pairEnd && pairOdd && !resvBad && !tgtBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perrQ <= 1'b0;
      ferrQ <= 1'b0;
    end else begin
      if (pairEnd && !pairOdd)             perrQ <= 1'b1;
      if (pairEnd && (resvBad || tgtBad))  ferrQ <= 1'b1;
    end
  end

  generate
    for (genvar k = 0; k < NUM_IDS; k++) begin : g_id
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          staged[k] <= idDefault(k);
        end else if (pairGood && (addrWord[TGT_W-1:0] == TGT_W'(k))) begin
          staged[k] <= shiftReg;
        end
      end
      assign idWords[k*WORD_W +: WORD_W] = done ? staged[k] : idDefault(k);
    end
  endgenerate

  assign finalFlag = addrWord[FIN_BIT];
  assign parityErr = perrQ;
  assign formatErr = ferrQ;

endmodule

// File: rtl/eeprom_id_loader.sv
`timescale 1ns/1ps
module eeprom_id_loader
  import idload_pkg::*;
#(
  parameter int SK_HALF = 2,
  parameter int ADDR_W  = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      eeDout,
  output logic                      eeCs,
  output logic                      eeSk,
  output logic                      eeDin,
  output logic                      done,
  output logic                      parityErr,
  output logic                      formatErr,
  output logic [NUM_IDS*WORD_W-1:0] idWords
);

  dpStrobe_t strb;
  logic      finalFlag;

  idload_ctrl #(
    .SK_HALF (SK_HALF),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .finalFlag (finalFlag),
    .strb      (strb),
    .eeCs      (eeCs),
    .eeSk      (eeSk),
    .eeDin     (eeDin),
    .done      (done)
  );

  idload_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .eeDout    (eeDout),
    .done      (done),
    .finalFlag (finalFlag),
    .idWords   (idWords),
    .parityErr (parityErr),
    .formatErr (formatErr)
  );

endmodule

// File: rtl/eeprom_id_loader_chk.sv
`timescale 1ns/1ps
module eeprom_id_loader_chk
  import idload_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic                      eeCs,
  input logic                      eeSk,
  input logic                      eeDin,
  input logic                      done,
  input logic                      parityErr,
  input logic                      formatErr,
  input logic [NUM_IDS*WORD_W-1:0] idWords
);

  logic [NUM_IDS*WORD_W-1:0] defWords;

  always_comb begin
    for (int k = 0; k < NUM_IDS; k++) defWords[k*WORD_W +: WORD_W] = idDefault(k);
  end

  a_r1_sk_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !eeCs |-> !eeSk);

  a_r1_din_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !eeCs |-> !eeDin);

  a_r8_no_frame_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !eeCs);

  a_r10_defaults_until_done: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (idWords == defWords));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  a_r10_words_frozen: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(idWords));

  a_r6_parity_sticky: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> parityErr);

  a_r7_format_sticky: assert property (@(posedge clk) disable iff (!rstN)
    formatErr |=> formatErr);

endmodule

bind eeprom_id_loader eeprom_id_loader_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .eeCs      (eeCs),
  .eeSk      (eeSk),
  .eeDin     (eeDin),
  .done      (done),
  .parityErr (parityErr),
  .formatErr (formatErr),
  .idWords   (idWords)
);

// File: tb/sim_eeprom_id_loader.sv
`timescale 1ns/1ps
module sim_eeprom_id_loader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eeDout;
  logic        eeCs, eeSk, eeDin, done, parityErr, formatErr;
  logic [95:0] idWords;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  eeprom_id_loader u0 (
    .clk(clk), .rstN(rstN), .eeDout(eeDout), .eeCs(eeCs), .eeSk(eeSk),
    .eeDin(eeDin), .done(done), .parityErr(parityErr), .formatErr(formatErr),
    .idWords(idWords)
  );

  // Reset values per R4
  localparam logic [15:0] DEFV [6] = '{16'h13A8, 16'h0352, 16'h0200, 16'h0700, 16'h0000, 16'h0000};

  // ---------------- EEPROM model ----------------
  logic [15:0] mem [64];
  logic [7:0]  mCmd;
  int          mCnt;
  logic [5:0]  mAddr;
  logic        mDo;
  int          mWords = 0;
  int          mCmdErr = 0;
  logic [5:0]  addrLog [1024];

  assign eeDout = mDo;

  always @(posedge eeSk or negedge eeCs) begin
    if (!eeCs) begin
      mCnt <= 0;
      mDo  <= 1'b0;
      mCmd <= '0;
    end else begin
      mCmd <= {mCmd[6:0], eeDin};
      mCnt <= mCnt + 1;
      if (mCnt == 8) begin
        mAddr <= {mCmd[4:0], eeDin};
        addrLog[mWords % 1024] <= {mCmd[4:0], eeDin};
        if (mCmd[7:5] != 3'b110) mCmdErr <= mCmdErr + 1;
        mWords <= mWords + 1;
        mDo <= 1'b0;
      end else if (mCnt >= 9 && mCnt <= 24) begin
        mDo <= mem[mAddr][24 - mCnt];
      end else begin
        mDo <= 1'b0;
      end
    end
  end

  // ---------------- checks ----------------
  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Entry: [31] present [30] last [29] corrupt parity [28] reserved bit set [23:16] target [15:0] data
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV][4] = '{
    '{32'hC001BEEF, 32'h0, 32'h0, 32'h0},
    '{32'h80051111, 32'h8000AAAA, 32'hC0035A5A, 32'h0},
    '{32'h80020001, 32'hC0020002, 32'h0, 32'h0},
    '{32'hA000DEAD, 32'hC0044444, 32'h0, 32'h0},
    '{32'h80069999, 32'h91017777, 32'hC0022222, 32'h0},
    '{32'h80033333, 32'h80040404, 32'h0, 32'h0},
    '{32'hC0050F0F, 32'h80005678, 32'h0, 32'h0},
    '{32'hE0011111, 32'h80022222, 32'h0, 32'h0}
  };

  task automatic putPair(input int idx, input bit fin, input bit badPar, input bit resv,
                         input logic [7:0] tgt, input logic [15:0] dat);
    logic [15:0] a;
    a = {1'b0, fin, resv ? 6'b000100 : 6'b000000, tgt};
    a[15] = ~(^{a[14:0], dat});
    if (badPar) a[15] = ~a[15];
    mem[2*idx]   = a;
    mem[2*idx+1] = dat;
  endtask

  logic [15:0] expW [6];
  logic        expP, expF;
  int          expN;

  // Reference from R3..R9
  task automatic refModel();
    bit stop;
    stop = 0;
    for (int k = 0; k < 6; k++) expW[k] = DEFV[k];
    expP = 0; expF = 0; expN = 0;
    for (int i = 0; i < 32 && !stop; i++) begin
      logic [15:0] a, d;
      bit par, bad;
      a = mem[2*i]; d = mem[2*i+1];
      par = ^{a, d};
      bad = (a[13:8] != 0) || (a[7:0] > 8'd5);
      if (!par) expP = 1;
      if (bad) expF = 1;
      if (par && !bad) expW[a[7:0]] = d;
      expN = 2*i + 2;
      if (a[14]) stop = 1;
    end
  endtask

  function automatic logic [95:0] packW();
    logic [95:0] v;
    for (int k = 0; k < 6; k++) v[16*k +: 16] = expW[k];
    return v;
  endfunction

  function automatic logic [95:0] packDef();
    logic [95:0] v;
    for (int k = 0; k < 6; k++) v[16*k +: 16] = DEFV[k];
    return v;
  endfunction

  task automatic runLoad(input string name);
    int base, n, bad, cmdBase;
    bit midDone;
    refModel();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    base = mWords; cmdBase = mCmdErr;
    rstN = 1'b1;
    midDone = 0;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk); n++;
      if (n == 150 && !midDone) begin
        midDone = 1;
        chk(!done && idWords == packDef(), {name, " R10 defaults mid-load"}, idWords, packDef());
      end
    end
    chk(done === 1'b1, {name, " R8 done"}, {95'd0, done}, 96'd1);
    chk(idWords == packW(), {name, " R3 R4 R5 R11 words"}, idWords, packW());
    chk(parityErr == expP, {name, " R6 parityErr"}, {95'd0, parityErr}, {95'd0, expP});
    chk(formatErr == expF, {name, " R7 formatErr"}, {95'd0, formatErr}, {95'd0, expF});
    chk(mWords - base == expN, {name, " R8 R9 words read"}, 96'(mWords - base), 96'(expN));
    bad = 0;
    for (int i = 0; i < mWords - base; i++)
      if (addrLog[(base + i) % 1024] != 6'(i)) bad++;
    chk(bad == 0, {name, " R2 address sequence"}, 96'(bad), 96'd0);
    chk(mCmdErr == cmdBase, {name, " R1 command bits"}, 96'(mCmdErr - cmdBase), 96'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    chk(done == 0 && eeCs == 0 && eeSk == 0, "R10 R1 reset outputs", {93'd0, done, eeCs, eeSk}, 96'd0);
    chk(idWords == packDef(), "R4 R11 reset words", idWords, packDef());
    chk(parityErr == 0 && formatErr == 0, "R6 R7 reset flags", {94'd0, parityErr, formatErr}, 96'd0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
      for (int j = 0; j < 4; j++) begin
        logic [31:0] e;
        e = VEC[v][j];
        if (e[31]) putPair(j, e[30], e[29], e[28], e[23:16], e[15:0]);
      end
      runLoad($sformatf("vec%0d", v));
    end

    // R9: every pair good and not last
    for (int i = 0; i < 32; i++) putPair(i, 1'b0, 1'b0, 1'b0, 8'(i % 6), 16'h0100 + 16'(i));
    runLoad("full R9");

    // R10: done and words held after load ends
    begin
      logic [95:0] snap;
      snap = idWords;
      repeat (300) @(negedge clk);
      chk(done == 1 && idWords == snap && eeCs == 0, "R10 hold after done", idWords, snap);
    end

    // R1: serial clock half period of 2 clocks during a frame
    begin
      int hi;
      @(negedge clk); rstN = 1'b0;
      repeat (2) @(negedge clk); rstN = 1'b1;
      while (!eeSk) @(negedge clk);
      hi = 0;
      while (eeSk) begin @(negedge clk); hi++; end
      chk(hi == 2, "R1 sk half period", 96'(hi), 96'd2);
      while (!done) @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule